// File: doc/BRIEF.md
# Banked GPIO Masked-Write Register File

This block holds the pin control state of a multi-bank general-purpose I/O controller with 32 pins per bank. A simple single-cycle register bus reaches it: address, write enable and write data go in, and read data comes back combinationally from the presented address. Each bank keeps a 32-bit output value, a direction word and an output-enable word. It also offers a read-only view of the pad inputs, which pass through a two-stage synchronizer first.

Each bank has two write-only masked ports, one for each half of its pins. A masked port changes any subset of one half-word of the output value in a single bus write. The upper 16 bits of the written word select which bits stay unchanged, and the lower 16 bits carry the new values. Software therefore never needs a read-modify-write to flip a single pin. A pin drives its pad only when its direction bit and its output-enable bit are both set.

An address decoder sorts every bus address into one of seven access kinds: none, masked low, masked high, full value, input view, direction, or output enable. It also picks the bank. Each bank slice applies writes according to that kind. A read multiplexer returns the selected word, or zero.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset, every output value, direction word and output-enable word is zero, so `pin_out` and `pin_oe` are all zero and every readable register returns zero.
- R2: The word at 0x040 + 4*N reads and writes the full 32-bit output value of bank N. Bit k drives `pin_out[32*N + k]`.
- R3: A write to 0x000 + 8*N updates pins 0..15 of bank N. Each of these pins takes `wdata[k]` where `wdata[16+k]` is 0 and keeps its value where `wdata[16+k]` is 1. Pins 16..31 do not change.
- R4: A write to 0x004 + 8*N acts the same way on pins 16..31 of bank N. Pin 16+k uses data bit k and mask bit 16+k. Pins 0..15 do not change.
- R5: Reads of any masked-write address (below 8*NUM_BANKS) return zero.
- R6: The word at 0x060 + 4*N returns bank N's `pin_in` as it was two rising edges earlier (two-flop synchronizer). Writes to that address change nothing.
- R7: The direction word of bank N at 0x204 + 0x40*N and its output-enable word at 0x208 + 0x40*N both read and write all 32 bits.
- R8: `pin_oe[32*N + k]` is 1 exactly when direction bit k and output-enable bit k of bank N are both 1.
- R9: Reads of an unmapped or unaligned address return zero, and writes to one change no state.
- R10: Writes take effect at the rising edge. A read of the same register in the write cycle returns the previous value. Without a write, `pin_out` and `pin_oe` hold.
- R11: A write changes only the bank that its address selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32*NUM_BANKS | Pad input values, bank N at bits 32*N+31..32*N |
| pin_out | output | 32*NUM_BANKS | Output values toward the pads |
| pin_oe | output | 32*NUM_BANKS | Tri-state drive enables toward the pads |

## Verification
The read path and the write path act in the same cycle whenever the bus writes a register that `bus_addr` also reads back. In that cycle the read must show the old contents, and the new contents must appear only after the edge. The bench provokes this on every write it issues, masked writes included, because read data is always compared against the model state from before the edge. During the same runs the pad inputs keep changing, so synchronizer shifts coincide with input-view reads, and each of those reads is judged against the pad value from two edges back.

// File: rtl/gpio_regfile_pkg.sv
package gpio_regfile_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int HALF_PINS     = PINS_PER_BANK / 2;

    // Base offsets; per-bank strides below.
    localparam int MASK_LO_BASE = 'h000;
    localparam int MASK_HI_BASE = 'h004;
    localparam int MASK_STRIDE  = 8;
    localparam int VALUE_BASE   = 'h040;
    localparam int INPUT_BASE   = 'h060;
    localparam int WORD_STRIDE  = 4;
    localparam int DIR_BASE     = 'h204;
    localparam int OE_BASE      = 'h208;
    localparam int CTRL_STRIDE  = 'h40;

    typedef enum logic [2:0] {
        RG_NONE    = 3'd0,
        RG_MASK_LO = 3'd1,
        RG_MASK_HI = 3'd2,
        RG_VALUE   = 3'd3,
        RG_INPUT   = 3'd4,
        RG_DIR     = 3'd5,
        RG_OE      = 3'd6
    } region_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regfile_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [BANK_W-1:0] bank
);

    always_comb begin
        region = RG_NONE;
        bank   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(MASK_LO_BASE + MASK_STRIDE * b)) begin
                region = RG_MASK_LO;
                bank   = BANK_W'(b);
            end
            if (addr == ADDR_W'(MASK_HI_BASE + MASK_STRIDE * b)) begin
                region = RG_MASK_HI;
                bank   = BANK_W'(b);
            end
            if (addr == ADDR_W'(VALUE_BASE + WORD_STRIDE * b)) begin
                region = RG_VALUE;
                bank   = BANK_W'(b);
            end
            if (addr == ADDR_W'(INPUT_BASE + WORD_STRIDE * b)) begin
                region = RG_INPUT;
                bank   = BANK_W'(b);
            end
            if (addr == ADDR_W'(DIR_BASE + CTRL_STRIDE * b)) begin
                region = RG_DIR;
                bank   = BANK_W'(b);
            end
            if (addr == ADDR_W'(OE_BASE + CTRL_STRIDE * b)) begin
                region = RG_OE;
                bank   = BANK_W'(b);
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
    import gpio_regfile_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic                     we,
    input  region_e                  region,
    input  logic [31:0]              wdata,
    output logic [PINS_PER_BANK-1:0] value_q,
    output logic [PINS_PER_BANK-1:0] dir_q,
    output logic [PINS_PER_BANK-1:0] oe_q
);

    logic [PINS_PER_BANK-1:0] value_d;
    logic [PINS_PER_BANK-1:0] dir_d;
    logic [PINS_PER_BANK-1:0] oe_d;
    logic [HALF_PINS-1:0]     keep_mask;
    logic [HALF_PINS-1:0]     new_bits;

    assign keep_mask = wdata[31:HALF_PINS];
    assign new_bits  = wdata[HALF_PINS-1:0];

    always_comb begin
        value_d = value_q;
        dir_d   = dir_q;
        oe_d    = oe_q;
        if (we && sel) begin
            unique case (region)
                RG_MASK_LO: value_d[HALF_PINS-1:0] =
                    (value_q[HALF_PINS-1:0] & keep_mask) | (new_bits & ~keep_mask);
                RG_MASK_HI: value_d[PINS_PER_BANK-1:HALF_PINS] =
                    (value_q[PINS_PER_BANK-1:HALF_PINS] & keep_mask) | (new_bits & ~keep_mask);
                RG_VALUE:   value_d = wdata;
                RG_DIR:     dir_d   = wdata;
                RG_OE:      oe_d    = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            dir_q   <= '0;
            oe_q    <= '0;
        end else begin
            value_q <= value_d;
            dir_q   <= dir_d;
            oe_q    <= oe_d;
        end
    end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
    import gpio_regfile_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_we,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic [PINS_PER_BANK*NUM_BANKS-1:0] pin_in,
    output logic [PINS_PER_BANK*NUM_BANKS-1:0] pin_out,
    output logic [PINS_PER_BANK*NUM_BANKS-1:0] pin_oe
);

    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int TOTAL_PINS = PINS_PER_BANK * NUM_BANKS;

    region_e                                   dec_region;
    logic [BANK_W-1:0]                         dec_bank;
    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0]   value_all;
    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0]   dir_all;
    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0]   oe_all;
    logic [TOTAL_PINS-1:0]                     sample_flat;
    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0]   sample_all;

    gpio_addr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W)
    ) u_decode (
        .addr   (bus_addr),
        .region (dec_region),
        .bank   (dec_bank)
    );

    gpio_in_sync #(
        .WIDTH (TOTAL_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sample_flat)
    );

    assign sample_all = sample_flat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_sel;
        assign bank_sel = (dec_bank == BANK_W'(b));

        gpio_bank_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (bank_sel),
            .we      (bus_we),
            .region  (dec_region),
            .wdata   (bus_wdata),
            .value_q (value_all[b]),
            .dir_q   (dir_all[b]),
            .oe_q    (oe_all[b])
        );

        assign pin_out[PINS_PER_BANK*b +: PINS_PER_BANK] = value_all[b];
        assign pin_oe[PINS_PER_BANK*b +: PINS_PER_BANK]  = dir_all[b] & oe_all[b];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (dec_region)
            RG_VALUE: bus_rdata = value_all[dec_bank];
            RG_INPUT: bus_rdata = sample_all[dec_bank];
            RG_DIR:   bus_rdata = dir_all[dec_bank];
            RG_OE:    bus_rdata = oe_all[dec_bank];
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_regfile_checker.sv
module gpio_regfile_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_we,
    input logic [31:0]               bus_wdata,
    input logic [31:0]               bus_rdata,
    input logic [32*NUM_BANKS-1:0]   pin_in,
    input logic [32*NUM_BANKS-1:0]   pin_out,
    input logic [32*NUM_BANKS-1:0]   pin_oe
);

    logic [1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_out == '0 && pin_oe == '0)); // R1

    AST_MASK_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_W'(8*NUM_BANKS)) |-> bus_rdata == '0); // R5

    AST_INPUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && bus_addr == ADDR_W'('h060)) |-> bus_rdata == $past(pin_in[31:0], 2)); // R6

    AST_OE_RISE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe[0]) |-> $past(bus_we)); // R8

    AST_UNALIGNED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> bus_rdata == '0); // R9

    AST_UNALIGNED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[1:0] != 2'b00) |=> ($stable(pin_out) && $stable(pin_oe))); // R9

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe))); // R10

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        AST_MASK_LO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(8*b)) |=>
            (pin_out[32*b +: 16] == (($past(pin_out[32*b +: 16]) & $past(bus_wdata[31:16])) |
                                     ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16])))
             && $stable(pin_out[32*b+16 +: 16]))); // R3

        AST_MASK_HI: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(8*b + 4)) |=>
            (pin_out[32*b+16 +: 16] == (($past(pin_out[32*b+16 +: 16]) & $past(bus_wdata[31:16])) |
                                        ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16])))
             && $stable(pin_out[32*b +: 16]))); // R4
    end

endmodule

bind gpio_bank_regfile gpio_regfile_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_gpio_bank_regfile.sv
`timescale 1ns/1ps
module tb_gpio_bank_regfile;

    localparam int NB = 4;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [32*NB-1:0]  pin_in = '0;
    logic [32*NB-1:0]  pin_out;
    logic [32*NB-1:0]  pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model state
    logic [31:0] m_val [NB];
    logic [31:0] m_dir [NB];
    logic [31:0] m_oe  [NB];
    logic [32*NB-1:0] m_s1, m_s2;

    always #4 clk = ~clk;

    gpio_bank_regfile #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(logic [AW-1:0] a);
        for (int b = 0; b < NB; b++) begin
            if (a == AW'(8*b))          return "R5 R10";
            if (a == AW'(8*b + 4))      return "R5 R10";
            if (a == AW'('h40 + 4*b))   return "R2 R10";
            if (a == AW'('h60 + 4*b))   return "R6";
            if (a == AW'('h204 + 64*b)) return "R7 R10";
            if (a == AW'('h208 + 64*b)) return "R7 R10";
        end
        return "R9";
    endfunction

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
        for (int b = 0; b < NB; b++) begin
            if (a == AW'('h40 + 4*b))   return m_val[b];
            if (a == AW'('h60 + 4*b))   return m_s2[32*b +: 32];
            if (a == AW'('h204 + 64*b)) return m_dir[b];
            if (a == AW'('h208 + 64*b)) return m_oe[b];
        end
        return 32'h0;
    endfunction

    function automatic logic [31:0] merge16(logic [31:0] old, logic [31:0] w, int hi);
        logic [31:0] r = old;
        for (int k = 0; k < 16; k++)
            if (!w[16+k]) r[hi*16 + k] = w[k];
        return r;
    endfunction

    task automatic model_write(logic [AW-1:0] a, logic [31:0] w);
        for (int b = 0; b < NB; b++) begin
            if (a == AW'(8*b))          m_val[b] = merge16(m_val[b], w, 0);
            if (a == AW'(8*b + 4))      m_val[b] = merge16(m_val[b], w, 1);
            if (a == AW'('h40 + 4*b))   m_val[b] = w;
            if (a == AW'('h204 + 64*b)) m_dir[b] = w;
            if (a == AW'('h208 + 64*b)) m_oe[b]  = w;
        end
    endtask

    function automatic logic [32*NB-1:0] exp_out();
        logic [32*NB-1:0] r;
        for (int b = 0; b < NB; b++) r[32*b +: 32] = m_val[b];
        return r;
    endfunction

    function automatic logic [32*NB-1:0] exp_oe();
        logic [32*NB-1:0] r;
        for (int b = 0; b < NB; b++) r[32*b +: 32] = m_dir[b] & m_oe[b];
        return r;
    endfunction

    // One bus cycle: drive at negedge, compare before the edge, update model at edge.
    task automatic step(logic [AW-1:0] a, logic we, logic [31:0] w);
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = w;
        #1;
        chk(tag_of(a), 128'(bus_rdata), 128'(exp_rd(a)));
        chk("R2 R11", 128'(pin_out), 128'(exp_out()));
        chk("R8", 128'(pin_oe), 128'(exp_oe()));
        @(posedge clk);
        m_s2 = m_s1;
        m_s1 = pin_in;
        if (we) model_write(a, w);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int b = 0; b < NB; b++) begin
            m_val[b] = '0; m_dir[b] = '0; m_oe[b] = '0;
        end
        m_s1 = '0; m_s2 = '0;
        pin_in = {NB{32'hDEAD_BEEF}};
        repeat (3) @(negedge clk);
        chk("R1", 128'(pin_out), 128'(0));
        chk("R1", 128'(pin_oe), 128'(0));
        rst_n = 1'b1;
        pin_in = '0;

        // R1: every readable word is zero after reset
        for (int b = 0; b < NB; b++) begin
            step(AW'('h40 + 4*b), 0, 0);
            step(AW'('h204 + 64*b), 0, 0);
            step(AW'('h208 + 64*b), 0, 0);
        end

        // R2, R10: full write, read in the write cycle shows old value
        step(AW'('h44), 1, 32'hA5A5_1234);
        step(AW'('h44), 0, 0);
        step(AW'('h44), 1, 32'h0F0F_F0F0);
        step(AW'('h44), 0, 0);

        // R3: masked low, bits 7:0 protected, 15:8 written
        step(AW'('h08), 1, 32'h00FF_ABCD);
        step(AW'('h44), 0, 0);
        step(AW'('h08), 1, 32'hFFFF_0000);  // all protected
        step(AW'('h08), 1, 32'h0000_5555);  // none protected
        step(AW'('h44), 0, 0);

        // R4: masked high on bank 2
        step(AW'('h48), 1, 32'h1234_5678);
        step(AW'('h14), 1, 32'hF00F_9AB3);
        step(AW'('h48), 0, 0);
        step(AW'('h14), 1, 32'h0000_FFFF);
        step(AW'('h48), 0, 0);

        // R5: masked addresses read zero
        step(AW'('h00), 0, 0);
        step(AW'('h14), 0, 0);

        // R6: input view two edges late; writes ignored
        for (int i = 0; i < 8; i++) begin
            pin_in = {NB{32'h1 << (i*4)}} ^ {32'hCAFE_0000 + 32'(i), 96'h0};
            step(AW'('h60 + 4*(i % NB)), (i == 3), 32'hFFFF_FFFF);
        end
        step(AW'('h6C), 1, 32'h1234_0000);
        step(AW'('h6C), 0, 0);

        // R7, R8: direction / output enable combinations on bank 3
        step(AW'('h2C4), 1, 32'h0000_FFFF);
        step(AW'('h2C8), 1, 32'h00FF_00FF);
        step(AW'('h2C4), 0, 0);
        step(AW'('h2C8), 0, 0);
        step(AW'('h2C4), 1, 32'h0);

        // R9: unmapped and unaligned accesses
        step(AW'('h030), 1, 32'hFFFF_FFFF);
        step(AW'('h041), 1, 32'hFFFF_FFFF);
        step(AW'('h202), 1, 32'hFFFF_FFFF);
        step(AW'('h3FC), 1, 32'hFFFF_FFFF);
        step(AW'('h041), 0, 0);

        // R11 and concurrency: pseudo-random traffic over mapped words
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            int b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = int'(lfsr[9:8]) % NB;
            case (lfsr[12:10])
                3'd0: a = AW'(8*b);
                3'd1: a = AW'(8*b + 4);
                3'd2: a = AW'('h40 + 4*b);
                3'd3: a = AW'('h60 + 4*b);
                3'd4: a = AW'('h204 + 64*b);
                3'd5: a = AW'('h208 + 64*b);
                default: a = AW'('h40 + 4*b);
            endcase
            pin_in = {pin_in[32*NB-2:0], lfsr[5]} ^ {NB{lfsr}};
            step(a, lfsr[13], {lfsr[7:0], lfsr[31:8]});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule